// File: doc/BRIEF.md
# Configuration Readback Error Checker

This block runs a background integrity check over a configuration image. Once enabled and started, it walks the image one word at a time through a synchronous read port. It takes exactly one bit per check-clock cycle and folds each bit into a CRC-32. At the end of the image it compares the result with a golden value supplied on an input port. A pass over N configuration bits therefore lasts about N check-clock cycles. The result is a single pass or fail flag for the whole image.

Software or surrounding logic drives the handshake with two inputs, `chk_en` and `chk_start`, and watches three outputs: `busy`, `done` and `err`. A rising edge on `chk_start` while the engine is idle starts a pass. If `chk_start` is simply held high, the engine starts again by itself after every completed pass, which gives continuous checking. A detected mismatch is latched in `err`. Only dropping `chk_en` or a reset clears it. Dropping `chk_en` also abandons any pass that is running.

Top module: `cfg_readback_chk`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `err` and `rd_en` are all low.
- R2: A rising edge of `chk_start` while `chk_en` is high and `busy` is low raises `busy` in the next cycle. In that same cycle `done` is driven low, even if it was high before.
- R3: `chk_start` has no effect while `chk_en` is low. It has no effect when it is already high at the moment `chk_en` rises. A rising edge of `chk_start` while `busy` is high does not change the length or the result of the pass.
- R4: During a pass, word addresses 0 to NUM_WORDS-1 are each read exactly once, in ascending order, with `rd_en` high for one cycle per read. `rd_en` is high only while `busy` is high.
- R5: The check value is CRC-32 with polynomial 0x04C11DB7. It starts at 0xFFFFFFFF, shifts the register MSB first, and applies no reflection and no final XOR. The input bits are fed from bit 0 up to bit WORD_W-1 of each word, and the words in ascending address order. A pass reports a mismatch when the final CRC differs from `golden_crc`.
- R6: `done` rises, and `busy` falls, exactly TOTAL_BITS+1 cycles after `busy` rose. In that same cycle `err` goes high if the pass mismatched.
- R7: Once `err` is high it stays high while `chk_en` stays high, including across later passes that match.
- R8: `chk_en` low in a cycle forces `busy`, `done` and `err` low in the next cycle. A pass in progress is abandoned without `done` rising.
- R9: With `chk_start` held high, `done` stays high for exactly one cycle after each pass. `busy` then rises in the following cycle and a new pass of the same length begins.
- R10: After a pass ends with `chk_start` low, `done` stays high until the next start or until `chk_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Check clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Check enable; low clears the error flag and aborts a pass |
| chk_start | input | 1 | Start request: edge in idle, level for back-to-back passes |
| golden_crc | input | 32 | Expected CRC-32 of the whole image |
| rd_en | output | 1 | Read strobe to the configuration image |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_data | input | WORD_W | Word returned one cycle after the read strobe, held until the next read |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | The last pass has completed |
| err | output | 1 | Sticky mismatch flag |

## Verification
The properties assume that `chk_en` and `chk_start` are synchronous to the check clock, and that `golden_crc` stays stable for the length of a pass. They also assume that the image returns the addressed word in the cycle after `rd_en` and holds it until the next read. The bench meets these conditions by driving every input on the falling clock edge. Its image model registers the read request and updates its output word only on a read strobe. It changes the golden value only between passes, never while `busy` is high.

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } chk_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic err;
    } chk_flags_t;

    // One serial CRC-32 step, MSB-first register, no reflection.
    function automatic logic [31:0] crc32_bit(input logic [31:0] crc, input logic din);
        logic fb;
        fb = crc[31] ^ din;
        return {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/cfg_chk_seq.sv
module cfg_chk_seq #(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 3,
    parameter int BIT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              last_bit
);
    logic [ADDR_W-1:0] word_q;
    logic [BIT_W-1:0]  bit_q;
    logic              word_end;
    logic              last_word;

    assign word_end  = (bit_q == BIT_W'(WORD_W - 1));
    assign last_word = (word_q == ADDR_W'(NUM_WORDS - 1));
    assign last_bit  = step && word_end && last_word;
    assign bit_idx   = bit_q;

    // The next word is requested while the last bit of the current one is used.
    always_comb begin
        rd_en   = load || (step && word_end && !last_word);
        rd_addr = load ? '0 : word_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            word_q <= '0;
            bit_q  <= '0;
        end else if (step) begin
            if (word_end) begin
                bit_q  <= '0;
                word_q <= last_word ? '0 : word_q + ADDR_W'(1);
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cfg_chk_crc.sv
module cfg_chk_crc
    import cfg_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        step,
    input  logic        din,
    output logic [31:0] crc_next
);
    logic [31:0] crc_q;

    assign crc_next = crc32_bit(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/cfg_chk_ctrl.sv
module cfg_chk_ctrl
    import cfg_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       start,
    input  logic       last_bit,
    input  logic       mismatch,
    output chk_state_e state,
    output chk_flags_t flags
);
    chk_state_e state_q;
    chk_flags_t flags_q;
    logic       start_q;

    assign state = state_q;
    assign flags = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start;
            if (!en) begin
                state_q <= ST_IDLE;
                flags_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (start && !start_q) begin
                            state_q      <= ST_LOAD;
                            flags_q.busy <= 1'b1;
                            flags_q.done <= 1'b0;
                        end
                    end
                    ST_LOAD: state_q <= ST_SHIFT;
                    ST_SHIFT: begin
                        if (last_bit) begin
                            state_q      <= ST_FIN;
                            flags_q.busy <= 1'b0;
                            flags_q.done <= 1'b1;
                            flags_q.err  <= flags_q.err | mismatch;
                        end
                    end
                    ST_FIN: begin
                        if (start) begin
                            state_q      <= ST_LOAD;
                            flags_q.busy <= 1'b1;
                            flags_q.done <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk
    import cfg_chk_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int TOTAL_BITS = 64,
    localparam int NUM_WORDS = TOTAL_BITS / WORD_W,
    localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic              chk_start,
    input  logic [31:0]       golden_crc,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    chk_state_e       state;
    chk_flags_t       flags;
    logic             load;
    logic             step;
    logic             last_bit;
    logic [BIT_W-1:0] bit_idx;
    logic             cur_bit;
    logic [31:0]      crc_next;

    assign load    = (state == ST_LOAD);
    assign step    = (state == ST_SHIFT);
    assign cur_bit = rd_data[bit_idx];

    cfg_chk_seq #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
    ) seq_i (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .rd_en(rd_en), .rd_addr(rd_addr), .bit_idx(bit_idx), .last_bit(last_bit)
    );

    cfg_chk_crc crc_i (
        .clk(clk), .rst(rst), .clear(load), .step(step),
        .din(cur_bit), .crc_next(crc_next)
    );

    cfg_chk_ctrl ctrl_i (
        .clk(clk), .rst(rst), .en(chk_en), .start(chk_start),
        .last_bit(last_bit), .mismatch(crc_next != golden_crc),
        .state(state), .flags(flags)
    );

    assign busy = flags.busy;
    assign done = flags.done;
    assign err  = flags.err;

endmodule

// File: rtl/cfg_readback_chk_sva.sv
module cfg_readback_chk_sva #(
    parameter int TOTAL_BITS = 64
) (
    input logic clk,
    input logic rst,
    input logic chk_en,
    input logic chk_start,
    input logic rd_en,
    input logic busy,
    input logic done,
    input logic err
);
    logic        start_d;
    logic [31:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_d  <= 1'b0;
            busy_cnt <= '0;
        end else begin
            start_d  <= chk_start;
            busy_cnt <= busy ? busy_cnt + 32'd1 : 32'd0;
        end
    end

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_start_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (chk_en && chk_start && !start_d && !busy) |=> (busy && !done));

    assert_read_in_pass_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    assert_pass_len_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($fell(busy) && busy_cnt == 32'(TOTAL_BITS + 1)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err && chk_en) |=> err);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> (!busy && !done && !err));

    assert_rerun_R9: assert property (@(posedge clk) disable iff (rst)
        (done && chk_en && chk_start) |=> busy);

    assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (done && chk_en && !chk_start) |=> done);

endmodule

bind cfg_readback_chk cfg_readback_chk_sva #(.TOTAL_BITS(TOTAL_BITS)) sva_i (
    .clk(clk), .rst(rst), .chk_en(chk_en), .chk_start(chk_start),
    .rd_en(rd_en), .busy(busy), .done(done), .err(err)
);

// File: tb/cfg_readback_chk_tb.sv
module cfg_readback_chk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 8;
    localparam int TOTAL_BITS = 64;
    localparam int NUM_WORDS  = TOTAL_BITS / WORD_W;
    localparam int ADDR_W     = $clog2(NUM_WORDS);
    localparam int PASS_CYC   = TOTAL_BITS + 2;

    // bit 32: golden matches; bits 31:0: image seed
    localparam logic [32:0] VECS [0:3] = '{
        {1'b1, 32'h1234_5678},
        {1'b0, 32'hDEAD_BEEF},
        {1'b1, 32'h0000_0000},
        {1'b0, 32'hFFFF_FFFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk_en = 1'b0;
    logic chk_start = 1'b0;
    logic [31:0] golden_crc = '0;
    logic rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data = '0;
    logic busy, done, err;

    logic [WORD_W-1:0] mem [NUM_WORDS];
    logic rd_en_s = 1'b0;
    logic [ADDR_W-1:0] addr_s = '0;
    logic log_clr = 1'b0;
    int rd_cnt = 0;
    int exp_addr = 0;
    bit addr_bad = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_readback_chk #(.WORD_W(WORD_W), .TOTAL_BITS(TOTAL_BITS)) dut_i (
        .clk(clk), .rst(rst), .chk_en(chk_en), .chk_start(chk_start),
        .golden_crc(golden_crc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err)
    );

    // Image model: request sampled mid-cycle, word returned on the next edge.
    always @(negedge clk) begin
        rd_en_s <= rd_en;
        addr_s  <= rd_addr;
    end
    always @(posedge clk) begin
        if (rd_en_s) rd_data <= mem[addr_s];
        if (log_clr) begin
            rd_cnt <= 0; exp_addr <= 0; addr_bad <= 1'b0;
        end else if (rd_en_s) begin
            if (int'(addr_s) != exp_addr) addr_bad <= 1'b1;
            exp_addr <= exp_addr + 1;
            rd_cnt   <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] image_crc();
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int w = 0; w < NUM_WORDS; w++)
            for (int b = 0; b < WORD_W; b++) begin
                if (c[31] ^ mem[w][b]) c = (c << 1) ^ 32'h04C1_1DB7;
                else                   c = c << 1;
            end
        return c;
    endfunction

    task automatic fill(input logic [31:0] seed);
        for (int i = 0; i < NUM_WORDS; i++)
            mem[i] = WORD_W'((seed * (i + 3)) ^ (seed >> i) ^ (i * 37));
    endtask

    // Called at a negedge; returns cycles from busy rising to done seen.
    task automatic run_pass(input bit keep_start, output int cyc);
        log_clr = 1'b1;
        chk_start = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        check(busy && !done, "R2", "busy/done after start", {busy, done}, 2'b10);
        cyc = 1;
        while (!done && cyc < 4 * PASS_CYC) begin
            @(negedge clk);
            cyc++;
        end
        if (!keep_start) chk_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] crc;
        fill(32'h0);
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !rd_en, "R1", "outputs in reset",
              {busy, done, err, rd_en}, 4'b0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !rd_en, "R1", "outputs after reset",
              {busy, done, err, rd_en}, 4'b0);

        // Vector table: each entry a full pass, err cleared first.
        for (int v = 0; v < 4; v++) begin
            chk_en = 1'b0;
            @(negedge clk);
            chk_en = 1'b1;
            fill(VECS[v][31:0]);
            crc = image_crc();
            golden_crc = VECS[v][32] ? crc : crc ^ 32'h0000_0100;
            run_pass(1'b0, cyc);
            check(cyc == PASS_CYC, "R6", "pass length", cyc, PASS_CYC);
            check(err == !VECS[v][32], "R5", "mismatch flag", err, !VECS[v][32]);
            check(rd_cnt == NUM_WORDS && !addr_bad, "R4", "read order",
                  rd_cnt, NUM_WORDS);
        end

        // R10: done held while idle.
        repeat (5) @(negedge clk);
        check(done && !busy, "R10", "done held in idle", {done, busy}, 2'b10);

        // R7: err sticky over a matching pass (err is 1 from the last vector).
        golden_crc = image_crc();
        run_pass(1'b0, cyc);
        check(err, "R7", "err after matching pass", err, 1);

        // R8: abort mid-pass clears everything.
        chk_start = 1'b1;
        repeat (20) @(negedge clk);
        chk_start = 1'b0;
        chk_en = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err, "R8", "abort clears", {busy, done, err}, 3'b0);
        repeat (2) @(negedge clk);
        check(!done, "R8", "done stays low after abort", done, 0);

        // R3: start ignored while disabled and when already high at enable.
        chk_start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!busy, "R3", "start while disabled", busy, 0);
        chk_en = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy, "R3", "start high before enable", busy, 0);
        chk_start = 1'b0;
        @(negedge clk);

        // R3: start edge during a pass does not change it.
        golden_crc = image_crc();
        chk_start = 1'b1;
        @(negedge clk);
        cyc = 1;
        chk_start = 1'b0;
        repeat (10) begin @(negedge clk); cyc++; end
        chk_start = 1'b1;
        @(negedge clk); cyc++;
        chk_start = 1'b0;
        while (!done && cyc < 4 * PASS_CYC) begin @(negedge clk); cyc++; end
        check(cyc == PASS_CYC, "R3", "length with start edge in pass", cyc, PASS_CYC);
        check(!err, "R3", "result with start edge in pass", err, 0);

        // R9: continuous checking with start held high.
        @(negedge clk);
        run_pass(1'b1, cyc);
        check(cyc == PASS_CYC, "R9", "first pass length", cyc, PASS_CYC);
        @(negedge clk);
        check(busy && !done, "R9", "restart after one done cycle", {busy, done}, 2'b10);
        cyc = 1;
        while (!done && cyc < 4 * PASS_CYC) begin @(negedge clk); cyc++; end
        check(cyc == PASS_CYC, "R9", "second pass length", cyc, PASS_CYC);
        chk_start = 1'b0;
        @(negedge clk);
        check(done && !busy, "R9", "stop when start released", {done, busy}, 2'b10);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule